// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Frame

This block is a small memory-mapped frame that converts message-signalled interrupt writes into single-cycle pulses on a bank of shared peripheral interrupt lines. A device writes to the frame's doorbell. The frame decodes a target interrupt ID from that write. If the ID falls inside the frame's owned window, the matching output line pulses once. The owned window starts at a base ID and has a fixed line count. Both are build-time parameters, and output bit `k` stands for interrupt ID `BASE_ID + k`.

Software discovers the window through a read-only type register and identifies the implementation through a fixed ID register. The frame supports three ways of decoding the target ID, selected by the `MODE` parameter:
- **Absolute:** the written data is the ID itself.
- **Offset:** a constant is added back to the written data. The constant is either the base ID or 32.
- **Address-only:** the ID comes from the write address and the data is ignored. In this mode the frame spans 8 KB.

The frame is parameterised, and the parameters must satisfy all of the following: the base ID is at least 32, the line count is nonzero, and base plus count is at most 1019. If they do not, the frame owns no IDs and never pulses.

Top module: `msi_line_frame`

## Requirements
- R1: A read at byte offset 0x008 returns the type word. Bits [25:16] hold `BASE_ID` and bits [9:0] hold `NUM_LINES`. All other bits are zero.
- R2: A read at byte offset 0xFCC returns the `IDENT` parameter.
- R3: Read data is registered and appears on the cycle after the read strobe. It is zero for any other offset (including the doorbell at 0x040) and on cycles with no read.
- R4: In absolute mode (`MODE`=0), a write to offset 0x040 with data `D` pulses line `D - BASE_ID` on the cycle after the write, provided `BASE_ID <= D < BASE_ID + NUM_LINES`.
- R5: A doorbell write whose decoded ID lies outside the owned window raises no pulse on any line.
- R6: Each accepted write drives its line high for exactly one cycle. Writes on consecutive cycles to the same ID keep the line high for one cycle per write, and at most one line is high in any cycle.
- R7: In the data-decoding modes, a write to any offset other than 0x040 causes no pulse. A write to 0x008 or 0xFCC leaves the value read back from that offset unchanged.
- R8: In offset modes, the decoded ID is the data plus a constant. `MODE`=1 uses `BASE_ID` as the constant and `MODE`=2 uses 32.
- R9: In address-only mode (`MODE`=3), any write anywhere in the 8 KB frame decodes ID `32 + (address >> 3)`, and the write data has no effect.
- R10: While reset is held, and directly after it is released, all lines are low and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one transfer per cycle |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 13 | Byte offset within the frame |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irqPulse | output | NUM_LINES | One-cycle pulse per owned interrupt line |

## Verification
A read and a doorbell write can land in the same cycle, because the bus carries both strobes. The two paths must not disturb each other: the read must return the register value unchanged while the write's pulse appears on the next cycle. The random phase raises both strobes independently on every transfer, so combined cycles occur often. It judges every such cycle by comparing both the read data and the pulse vectors of four differently configured frames against bench-computed values. Directed sequences add two more cases: back-to-back writes to one ID, and writes to read-only offsets followed by a read of the same offset.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;
  localparam int FRAME_AW      = 13;
  localparam int IDX_W         = 10;
  localparam int MIN_ID        = 32;
  localparam int MAX_ID        = 1019;
  localparam int MODE_ABS      = 0;
  localparam int MODE_OFS_BASE = 1;
  localparam int MODE_OFS_32   = 2;
  localparam int MODE_ADDR     = 3;
  localparam logic [FRAME_AW-1:0] OFS_TYPE  = 13'h008;
  localparam logic [FRAME_AW-1:0] OFS_DOOR  = 13'h040;
  localparam logic [FRAME_AW-1:0] OFS_IDENT = 13'hFCC;

  typedef enum logic [1:0] {SEL_NONE, SEL_TYPE, SEL_IDENT} rdSel_e;

  typedef struct packed {
    logic             fire;
    logic [IDX_W-1:0] lineIdx;
    rdSel_e           rdSel;
  } frameStrobe_t;
endpackage

// File: rtl/msi_frame_ctrl.sv
module msi_frame_ctrl
  import msi_frame_pkg::*;
#(
  parameter int BASE_ID   = 64,
  parameter int NUM_LINES = 32,
  parameter int MODE      = MODE_ABS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [FRAME_AW-1:0] busAddr,
  input  logic [31:0]         busWrData,
  output frameStrobe_t        strb
);
  localparam int  OFFSET   = (MODE == MODE_OFS_BASE) ? BASE_ID :
                             (MODE == MODE_OFS_32)   ? MIN_ID  : 0;
  localparam int  LIMIT    = BASE_ID + NUM_LINES;
  localparam bit  RANGE_OK = (BASE_ID >= MIN_ID) && (NUM_LINES > 0) && (LIMIT <= MAX_ID);
  localparam bit  ADDR_SEL = (MODE == MODE_ADDR);

  logic [33:0] absId;
  logic        hit;
  logic        owned;

  always_comb begin
    if (ADDR_SEL) begin
      absId = 34'(busAddr[FRAME_AW-1:3]) + 34'(MIN_ID);
      hit   = busWrEn;
    end else begin
      absId = {2'b00, busWrData} + 34'(OFFSET);
      hit   = busWrEn && (busAddr == OFS_DOOR);
    end
    owned        = RANGE_OK && (absId >= 34'(BASE_ID)) && (absId < 34'(LIMIT));
    strb.fire    = hit && owned;
    strb.lineIdx = IDX_W'(absId - 34'(BASE_ID));
    if (!busRdEn)                  strb.rdSel = SEL_NONE;
    else if (busAddr == OFS_TYPE)  strb.rdSel = SEL_TYPE;
    else if (busAddr == OFS_IDENT) strb.rdSel = SEL_IDENT;
    else                           strb.rdSel = SEL_NONE;
  end

  // R4
  fire_needs_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> busWrEn);
  // R5
  fire_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> (strb.lineIdx < IDX_W'(NUM_LINES)));
endmodule

// File: rtl/msi_frame_dp.sv
module msi_frame_dp
  import msi_frame_pkg::*;
#(
  parameter int          BASE_ID   = 64,
  parameter int          NUM_LINES = 32,
  parameter logic [31:0] IDENT     = 32'h0A11_0143
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  frameStrobe_t         strb,
  output logic [31:0]          busRdData,
  output logic [NUM_LINES-1:0] irqPulse
);
  localparam logic [31:0] TYPE_WORD = {6'b0, IDX_W'(BASE_ID), 6'b0, IDX_W'(NUM_LINES)};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic pulseQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pulseQ <= 1'b0;
      else       pulseQ <= strb.fire && (strb.lineIdx == IDX_W'(g));
    end
    assign irqPulse[g] = pulseQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdData <= '0;
    else begin
      unique case (strb.rdSel)
        SEL_TYPE:  busRdData <= TYPE_WORD;
        SEL_IDENT: busRdData <= IDENT;
        default:   busRdData <= '0;
      endcase
    end
  end

  // R6
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqPulse));
  // R6
  pulse_needs_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|irqPulse) |-> $past(strb.fire));
  // R3
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData != 32'd0) |-> $past(strb.rdSel != SEL_NONE));
endmodule

// File: rtl/msi_line_frame.sv
module msi_line_frame
  import msi_frame_pkg::*;
#(
  parameter int          BASE_ID   = 64,
  parameter int          NUM_LINES = 32,
  parameter int          MODE      = MODE_ABS,
  parameter logic [31:0] IDENT     = 32'h0A11_0143
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [12:0]          busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  output logic [NUM_LINES-1:0] irqPulse
);
  frameStrobe_t strb;

  msi_frame_ctrl #(.BASE_ID(BASE_ID), .NUM_LINES(NUM_LINES), .MODE(MODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .strb(strb)
  );

  msi_frame_dp #(.BASE_ID(BASE_ID), .NUM_LINES(NUM_LINES), .IDENT(IDENT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busRdData(busRdData), .irqPulse(irqPulse)
  );
endmodule

// File: tb/msi_line_frame_tb.sv
module msi_line_frame_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdA, rdB, rdC, rdD;
  logic [31:0] pA;
  logic [15:0] pB;
  logic [23:0] pC;
  logic [7:0]  pD;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  msi_line_frame #(.BASE_ID(64), .NUM_LINES(32), .MODE(0), .IDENT(32'h0A11_0143)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(wrEn), .busRdEn(rdEn), .busAddr(addr),
    .busWrData(wdata), .busRdData(rdA), .irqPulse(pA));
  msi_line_frame #(.BASE_ID(96), .NUM_LINES(16), .MODE(1), .IDENT(32'h0000_0B01)) u_dutOfs (
    .clk(clk), .rstN(rstN), .busWrEn(wrEn), .busRdEn(rdEn), .busAddr(addr),
    .busWrData(wdata), .busRdData(rdB), .irqPulse(pB));
  msi_line_frame #(.BASE_ID(40), .NUM_LINES(24), .MODE(3), .IDENT(32'h0000_0C02)) u_dutAdr (
    .clk(clk), .rstN(rstN), .busWrEn(wrEn), .busRdEn(rdEn), .busAddr(addr),
    .busWrData(wdata), .busRdData(rdC), .irqPulse(pC));
  msi_line_frame #(.BASE_ID(200), .NUM_LINES(8), .MODE(2), .IDENT(32'h0000_0D03)) u_dut32 (
    .clk(clk), .rstN(rstN), .busWrEn(wrEn), .busRdEn(rdEn), .busAddr(addr),
    .busWrData(wdata), .busRdData(rdD), .irqPulse(pD));

  function automatic logic [31:0] expPulse(int mode, int base, int n,
                                           logic wr, logic [12:0] a, logic [31:0] d);
    longint id;
    logic [31:0] v = '0;
    if (!wr) return v;
    if (mode == 3) id = 32 + longint'(a >> 3);
    else begin
      if (a != 13'h040) return v;
      id = longint'({32'b0, d}) + ((mode == 1) ? base : (mode == 2) ? 32 : 0);
    end
    if (id >= base && id < base + n) v[id - base] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] expRead(logic rd, logic [12:0] a, int base, int n,
                                          logic [31:0] ident);
    if (!rd) return 32'd0;
    if (a == 13'h008) return {6'b0, 10'(base), 6'b0, 10'(n)};
    if (a == 13'hFCC) return ident;
    return 32'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus transfer; outputs sampled 1 ns after the capturing edge
  task automatic step(string req, logic wr, logic rd, logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = wr; rdEn = rd; addr = a; wdata = d;
    @(posedge clk);
    #1;
    check({req, " abs pulse"},  pA,              expPulse(0, 64, 32, wr, a, d));
    check({req, " base pulse"}, {16'b0, pB},     expPulse(1, 96, 16, wr, a, d));
    check({req, " addr pulse"}, {8'b0, pC},      expPulse(3, 40, 24, wr, a, d));
    check({req, " c32 pulse"},  {24'b0, pD},     expPulse(2, 200, 8, wr, a, d));
    check({req, " rd abs"},     rdA, expRead(rd, a, 64, 32, 32'h0A11_0143));
    check({req, " rd addr"},    rdC, expRead(rd, a, 40, 24, 32'h0000_0C02));
    check({req, " rd c32"},     rdD, expRead(rd, a, 200, 8, 32'h0000_0D03));
    check({req, " rd base"},    rdB, expRead(rd, a, 96, 16, 32'h0000_0B01));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset pulses", pA, 32'd0);
    check("R10 reset rd", rdA, 32'd0);
    @(negedge clk); rstN = 1'b1;
    step("R10 idle", 1'b0, 1'b0, 13'h0, 32'h0);
    step("R1 type", 1'b0, 1'b1, 13'h008, 32'h0);
    check("R1 type literal", rdA, 32'h0040_0020);
    step("R2 ident", 1'b0, 1'b1, 13'hFCC, 32'h0);
    step("R3 doorbell read", 1'b0, 1'b1, 13'h040, 32'h0);
    step("R3 unmapped", 1'b0, 1'b1, 13'h1008, 32'h0);
    step("R4 low edge", 1'b1, 1'b0, 13'h040, 32'd64);
    check("R4 bit0", pA, 32'h1);
    step("R4 high edge", 1'b1, 1'b0, 13'h040, 32'd95);
    check("R4 bit31", pA, 32'h8000_0000);
    step("R5 below", 1'b1, 1'b0, 13'h040, 32'd63);
    step("R5 above", 1'b1, 1'b0, 13'h040, 32'd96);
    step("R5 huge", 1'b1, 1'b0, 13'h040, 32'hFFFF_FFFF);
    step("R6 b2b one", 1'b1, 1'b0, 13'h040, 32'd70);
    step("R6 b2b two", 1'b1, 1'b0, 13'h040, 32'd70);
    step("R6 drop", 1'b0, 1'b0, 13'h040, 32'd70);
    check("R6 low after", pA, 32'd0);
    step("R7 wr type", 1'b1, 1'b0, 13'h008, 32'hFFFF_FFFF);
    step("R7 rd type", 1'b0, 1'b1, 13'h008, 32'h0);
    step("R7 wr ident", 1'b1, 1'b0, 13'hFCC, 32'd70);
    step("R7 rd ident", 1'b0, 1'b1, 13'hFCC, 32'h0);
    step("R8 base ofs", 1'b1, 1'b0, 13'h040, 32'd5);
    check("R8 base bit5", {16'b0, pB}, 32'h20);
    step("R8 c32 ofs", 1'b1, 1'b0, 13'h040, 32'd175);
    check("R8 c32 bit7", {24'b0, pD}, 32'h80);
    step("R9 addr a", 1'b1, 1'b0, 13'h0040, 32'd0);
    check("R9 id40 bit0", {8'b0, pC}, 32'h1);
    step("R9 addr b", 1'b1, 1'b0, 13'h0040, 32'hDEAD_BEEF);
    check("R9 data ignored", {8'b0, pC}, 32'h1);
    step("R9 last", 1'b1, 1'b0, 13'h00F8, 32'd3);
    step("R9 past", 1'b1, 1'b1, 13'h1000, 32'd3);
    for (int i = 0; i < 3000; i++) begin
      logic [12:0] a;
      logic [31:0] d;
      int pick = $urandom % 8;
      a = (pick < 4) ? 13'h040 : (pick == 4) ? 13'h008 : (pick == 5) ? 13'hFCC :
          13'($urandom % 8192);
      d = (pick == 7) ? $urandom : 32'(($urandom % 260) + 20);
      step("R3 R4 R5 R8 R9 random", 1'($urandom % 4 != 0), 1'($urandom % 2), a, d);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule